// File: doc/BRIEF.md
# Bidirectional Gate Row Scanner

This block selects the rows of an active-matrix panel one after another. It has `NUM_ROWS` logic-level select lines, 240 by default. A vertical start pulse places a select token at the entry row. Each rising edge of the shift clock then moves the token one row further. The direction input chooses whether the scan starts at line 0 and runs upward, or starts at the last line and runs downward.

Two mode inputs choose the scan style:

- one select window per row;
- two back-to-back windows per row, so that neighbouring rows overlap;
- two windows per row with a one-step gap between them;
- all lines held low.

Two devices can share one start pulse to drive a panel twice as tall. The device in the second position counts shift clocks after the start pulse and launches its own token when the first device's token leaves that device's last row. No carry wire is needed. The position comes from the direction input together with the chain-position input.

Top module: `gate_scan_top`

## Requirements
- R1: A synchronous reset (`rst_n` low at a clock edge) clears every pending token and count. All `gate` lines are low after that edge and stay low until a new start is accepted.
- R2: When `dir_fwd` is 1, scan step k selects `gate[k]`. A token therefore moves from `gate[0]` toward `gate[NUM_ROWS-1]`, one line per clock.
- R3: When `dir_fwd` is 0, scan step k selects `gate[NUM_ROWS-1-k]`. A token therefore moves from the last line toward `gate[0]`.
- R4: With `{mode_a,mode_b}` = 2'b11, each row is high for exactly one clock step, and only one row is high at a time within a frame.
- R5: With `{mode_a,mode_b}` = 2'b01, each row is high for two consecutive clock steps.
- R6: With `{mode_a,mode_b}` = 2'b10, each row is high at scan step k and at step k+2, and is low at step k+1.
- R7: With `{mode_a,mode_b}` = 2'b00, every `gate` line is low at once. Tokens keep advancing while the lines are blanked, and reappear in their advanced positions when a scanning mode returns.
- R8: A start is accepted at a clock edge where `start_in` is 1, but only if it was 0 at the previous edge. Holding `start_in` high launches nothing further. The first edge after reset counts `start_in` as previously 0.
- R9: The device is first in the chain when `dir_fwd` equals `chain_sel`. A first device shows its entry row high right after the edge that accepts the start.
- R10: The device is second in the chain when `dir_fwd` differs from `chain_sel`. A second device does not react to the start directly.
- R11: A second device launches its token `NUM_ROWS` edges after the accepting edge, and uses the mode that is present at that launch edge.
- R12: A start accepted in the middle of a frame on a first device adds a new token while the old one keeps moving. On a second device it restarts the `NUM_ROWS`-edge count, and the launch from the earlier start is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Vertical shift clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_in | input | 1 | Vertical start pulse, sampled on `clk` |
| dir_fwd | input | 1 | 1: scan from line 0 upward; 0: scan from the last line downward |
| chain_sel | input | 1 | Chain-position input, decoded together with `dir_fwd` |
| mode_a | input | 1 | Scan-style select, high bit |
| mode_b | input | 1 | Scan-style select, low bit |
| gate | output | NUM_ROWS | Row select lines, 1 = selected |

## Verification
A corrupted token chain shows up as a misplaced or missing select line within one clock. A defect in the shift path shows up once the token reaches that row, at most `NUM_ROWS` clocks later. A wrong launch-pattern bit shows up in the two clocks after the launch, as a missing or extra second window. A wrong cascade count or a wrong position decode becomes visible only at the hand-over point. That point is `NUM_ROWS` clocks after the start, where the entry row lights up too early, too late, or not at all.

// File: rtl/gsd_pkg.sv
// Shared types for the gate row scanner.
// Assumes the mode is taken as {mode_a, mode_b}.
package gsd_pkg;

    typedef enum logic [1:0] {
        SCAN_OFF    = 2'b00,
        SCAN_CONT   = 2'b01,
        SCAN_JUMP   = 2'b10,
        SCAN_NORMAL = 2'b11
    } scan_mode_e;

    localparam int BURST_LEN = 3;

    // Token bits injected on three successive steps; bit 0 goes first.
    function automatic logic [BURST_LEN-1:0] burst_pattern(scan_mode_e m);
        case (m)
            SCAN_CONT: return 3'b011;
            SCAN_JUMP: return 3'b101;
            default:   return 3'b001;
        endcase
    endfunction

endpackage

// File: rtl/gsd_launch_ctrl.sv
// Start acceptance and cascade delay.
// Raises `launch` on the edge that must place a new token at the entry row.
// A first device launches on an accepted start. A second device launches
// ROWS edges after the accepted start.
// Assumes start_in is synchronous to clk.
module gsd_launch_ctrl #(
    parameter int ROWS = 240
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_in,
    input  logic first_pos,
    output logic launch
);
    localparam int CW = $clog2(ROWS + 1);
    localparam logic [CW-1:0] LOAD = CW'(ROWS);

    logic          start_seen;
    logic [CW-1:0] dly_cnt;
    logic          accept;

    // An accepted start is a high sample that follows a low one.
    assign accept = start_in && !start_seen;
    assign launch = first_pos ? accept : (dly_cnt == CW'(1));

    // Keep the start history and run the cascade countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_seen <= 1'b0;
            dly_cnt    <= '0;
        end else begin
            start_seen <= start_in;
            if (accept && !first_pos)
                dly_cnt <= LOAD;
            else if (dly_cnt != '0)
                dly_cnt <= dly_cnt - CW'(1);
        end
    end
endmodule

// File: rtl/gsd_token_chain.sv
// Token shift chain in scan order: bit 0 is the entry row.
// On launch it injects a three-step burst pattern, one bit per clock.
// Assumes ROWS >= 2.
module gsd_token_chain
    import gsd_pkg::*;
#(
    parameter int ROWS = 240
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 launch,
    input  logic [BURST_LEN-1:0] pattern,
    output logic [ROWS-1:0]      chain
);
    logic [BURST_LEN-2:0] pend;
    logic                 entry;

    // Bit fed into the entry row this step.
    assign entry = launch ? pattern[0] : pend[0];

    // Move all tokens one row and refill the burst pipeline.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend  <= '0;
            chain <= '0;
        end else begin
            pend  <= launch ? pattern[BURST_LEN-1:1] : {1'b0, pend[BURST_LEN-2:1]};
            chain <= {chain[ROWS-2:0], entry};
        end
    end
endmodule

// File: rtl/gsd_row_map.sv
// Maps scan-order chain bits onto physical lines according to the
// direction, and blanks every line when disabled. Purely combinational.
module gsd_row_map #(
    parameter int ROWS = 240
) (
    input  logic [ROWS-1:0] chain,
    input  logic            dir_fwd,
    input  logic            enable,
    output logic [ROWS-1:0] gate
);
    // One mux per line: a forward or a mirrored index.
    for (genvar i = 0; i < ROWS; i++) begin : g_line
        assign gate[i] = enable && (dir_fwd ? chain[i] : chain[ROWS-1-i]);
    end
endmodule

// File: rtl/gate_scan_top.sv
// Bidirectional gate row scanner with two-device cascade by clock counting.
// Assumes one token step per rising edge of clk, which is the shift clock.
module gate_scan_top
    import gsd_pkg::*;
#(
    parameter int NUM_ROWS = 240
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_in,
    input  logic                dir_fwd,
    input  logic                chain_sel,
    input  logic                mode_a,
    input  logic                mode_b,
    output logic [NUM_ROWS-1:0] gate
);
    scan_mode_e           mode;
    logic                 first_pos;
    logic                 launch;
    logic [BURST_LEN-1:0] pattern;
    logic [NUM_ROWS-1:0]  chain;

    // Decode the mode, the chain position and the burst shape.
    always_comb begin
        mode      = scan_mode_e'({mode_a, mode_b});
        first_pos = (dir_fwd == chain_sel);
        pattern   = burst_pattern(mode);
    end

    gsd_launch_ctrl #(.ROWS(NUM_ROWS)) u_launch (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_in  (start_in),
        .first_pos (first_pos),
        .launch    (launch)
    );

    gsd_token_chain #(.ROWS(NUM_ROWS)) u_chain (
        .clk     (clk),
        .rst_n   (rst_n),
        .launch  (launch),
        .pattern (pattern),
        .chain   (chain)
    );

    gsd_row_map #(.ROWS(NUM_ROWS)) u_map (
        .chain   (chain),
        .dir_fwd (dir_fwd),
        .enable  (mode != SCAN_OFF),
        .gate    (gate)
    );
endmodule

// File: rtl/gsd_scan_checker.sv
// Temporal checks on the scanner ports, attached by bind.
module gsd_scan_checker #(
    parameter int N = 240
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start_in,
    input logic         dir_fwd,
    input logic         chain_sel,
    input logic         mode_a,
    input logic         mode_b,
    input logic [N-1:0] gate
);
    localparam int QUIET = 2 * N + 8;
    localparam int QW    = $clog2(QUIET + 1);

    logic          live;
    logic          prev_start;
    logic [1:0]    prev_mode;
    logic [QW-1:0] quiet_cnt;
    logic          on;
    logic          first;

    assign on    = mode_a || mode_b;
    assign first = (dir_fwd == chain_sel);

    // Track how long the device has been out of reset, the start history,
    // and how long the mode has been steady.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live       <= 1'b0;
            prev_start <= 1'b0;
            prev_mode  <= 2'b00;
            quiet_cnt  <= '0;
        end else begin
            live       <= 1'b1;
            prev_start <= start_in;
            prev_mode  <= {mode_a, mode_b};
            if (prev_mode != {mode_a, mode_b})
                quiet_cnt <= '0;
            else if (quiet_cnt != QW'(QUIET))
                quiet_cnt <= quiet_cnt + QW'(1);
        end
    end

    AST_OFF_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_a && !mode_b) |-> (gate == '0)); // R7

    AST_FWD_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (live && dir_fwd && $past(dir_fwd) && on && $past(on))
        |-> (gate[N-1:1] == $past(gate[N-2:0]))); // R2

    AST_REV_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (live && !dir_fwd && !$past(dir_fwd) && on && $past(on))
        |-> (gate[N-2:0] == $past(gate[N-1:1]))); // R3

    AST_FIRST_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (first && on && start_in && !prev_start)
        |=> ((!mode_a && !mode_b) || ($past(dir_fwd) ? gate[0] : gate[N-1]))); // R9

    AST_CONT_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet_cnt == QW'(QUIET) && !mode_a && mode_b)
        |-> ((($past(gate) & ~$past(gate, 2)) & ~gate) == '0)); // R5
endmodule

bind gate_scan_top gsd_scan_checker #(.N(NUM_ROWS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_in  (start_in),
    .dir_fwd   (dir_fwd),
    .chain_sel (chain_sel),
    .mode_a    (mode_a),
    .mode_b    (mode_b),
    .gate      (gate)
);

// File: tb/sim_gate_scan_top.sv
// Self-checking bench for gate_scan_top, driven by a table of scenarios
// and followed by directed tests.
module sim_gate_scan_top;
    localparam int N = 240;
    localparam int NL = 8;

    logic         clk = 1'b0;
    logic         rst_n, start_in, dir_fwd, chain_sel, mode_a, mode_b;
    logic [N-1:0] gate;

    int n_checks = 0;
    int n_fail   = 0;

    // Reference model state: launch times and their burst shapes.
    int       ec = 0;
    int       l_time [NL];
    logic [2:0] l_pat [NL];
    logic     l_use [NL];
    int       pend = -1;
    logic     prev_s = 1'b0;

    // Case fields: {dir_fwd, chain_sel, mode_a, mode_b, retrigger, hold}
    localparam logic [5:0] CASES [10] = '{
        6'b111100, 6'b001100, 6'b101100, 6'b010101, 6'b110100,
        6'b001000, 6'b101000, 6'b110000, 6'b111110, 6'b011110
    };

    gate_scan_top #(.NUM_ROWS(N)) u0 (
        .clk(clk), .rst_n(rst_n), .start_in(start_in), .dir_fwd(dir_fwd),
        .chain_sel(chain_sel), .mode_a(mode_a), .mode_b(mode_b), .gate(gate)
    );

    always #2 clk = ~clk;

    initial begin
        #(200000 * 4);
        n_fail++;
        $display("FAIL R1 watchdog expired: got hung, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    function automatic logic [2:0] pat_of(logic a, logic b);
        case ({a, b})
            2'b01:   return 3'b011;
            2'b10:   return 3'b101;
            default: return 3'b001;
        endcase
    endfunction

    task automatic add_launch(int t);
        for (int j = 0; j < NL; j++) begin
            if (!l_use[j] || l_time[j] < t - N - 4) begin
                l_use[j]  = 1'b1;
                l_time[j] = t;
                l_pat[j]  = pat_of(mode_a, mode_b);
                return;
            end
        end
    endtask

    task automatic clear_model();
        for (int j = 0; j < NL; j++) l_use[j] = 1'b0;
        pend   = -1;
        prev_s = 1'b0;
    endtask

    function automatic logic [N-1:0] expect_gate();
        logic [N-1:0] e = '0;
        if (!mode_a && !mode_b) return e;
        for (int j = 0; j < NL; j++) begin
            if (!l_use[j]) continue;
            for (int o = 0; o < 3; o++) begin
                int k = ec - l_time[j] - o;
                if (l_pat[j][o] && k >= 0 && k < N)
                    e[dir_fwd ? k : N - 1 - k] = 1'b1;
            end
        end
        return e;
    endfunction

    // Advance the model for the coming edge, clock once, then settle.
    task automatic step();
        ec++;
        if (!rst_n) begin
            clear_model();
        end else begin
            if (pend == ec) begin
                add_launch(ec);
                pend = -1;
            end
            if (start_in && !prev_s) begin
                if (dir_fwd == chain_sel) add_launch(ec);
                else pend = ec + N;
            end
            prev_s = start_in;
        end
        @(posedge clk);
        #1;
    endtask

    task automatic check(string tag);
        logic [N-1:0] e = expect_gate();
        n_checks++;
        if (gate !== e) begin
            n_fail++;
            $display("FAIL %s edge %0d: got %h expected %h", tag, ec, gate, e);
        end
    endtask

    task automatic do_reset(string tag);
        rst_n = 1'b0;
        for (int i = 0; i < 3; i++) step();
        check(tag);
        rst_n = 1'b1;
    endtask

    initial begin
        rst_n = 1'b0; start_in = 1'b0; dir_fwd = 1'b1; chain_sel = 1'b1;
        mode_a = 1'b0; mode_b = 1'b0;
        clear_model();

        // Table-driven scan of directions, modes, chain positions, restarts.
        for (int c = 0; c < 10; c++) begin
            string tag;
            logic [5:0] v = CASES[c];
            dir_fwd = v[5]; chain_sel = v[4]; mode_a = v[3]; mode_b = v[2];
            tag = $sformatf("case%0d %s %s %s%s%s", c,
                  v[5] ? "R2" : "R3",
                  (v[5] == v[4]) ? "R9" : "R10/R11",
                  ({v[3], v[2]} == 2'b11) ? "R4" : ({v[3], v[2]} == 2'b01) ? "R5" :
                  ({v[3], v[2]} == 2'b10) ? "R6" : "R7",
                  v[1] ? " R12" : "", v[0] ? " R8" : "");
            do_reset("R1 reset state");
            start_in = 1'b1;
            for (int i = 0; i < (v[0] ? 3 : 1); i++) begin step(); check(tag); end
            start_in = 1'b0;
            for (int i = 0; i < 2 * N + 110; i++) begin
                if (v[1] && i == 100) start_in = 1'b1;
                if (v[1] && i == 101) start_in = 1'b0;
                step();
                check(tag);
            end
        end

        // R7: blank mid-frame, then return to scanning at the advanced position.
        dir_fwd = 1'b1; chain_sel = 1'b1; mode_a = 1'b1; mode_b = 1'b1;
        do_reset("R1 reset state");
        start_in = 1'b1; step(); check("R9 entry"); start_in = 1'b0;
        for (int i = 0; i < 120; i++) begin
            if (i == 40) begin mode_a = 1'b0; mode_b = 1'b0; end
            if (i == 70) begin mode_a = 1'b1; mode_b = 1'b1; end
            step();
            check("R7 blank and resume");
        end

        // R1: reset in the middle of a frame clears all tokens.
        rst_n = 1'b0; step(); check("R1 mid-frame reset");
        rst_n = 1'b1;
        for (int i = 0; i < 20; i++) begin step(); check("R1 stays low"); end

        // R8: start held high across reset release launches on the first edge.
        start_in = 1'b1; rst_n = 1'b0; step(); check("R1 reset state");
        rst_n = 1'b1; step(); check("R8 launch after reset");
        for (int i = 0; i < 10; i++) begin step(); check("R8 held high"); end
        start_in = 1'b0;
        for (int i = 0; i < 20; i++) begin step(); check("R8 tail"); end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule